// File: doc/BRIEF.md
# Dual-Mode Fixed-Point Multiply-Accumulate Unit

This block is a signed fixed-point multiply-accumulate datapath. One array of four 17x17 signed partial-product multipliers gives either a single signed 32x32 product or two independent signed 16x16 products. The two 16x16 products are formed from the high halves and the low halves of the two operands. Each product passes through a shifter that moves it left or right by 0 to 16 bit positions. The shifted value then goes to an adder/subtractor that can saturate its result. The results are held in a 32-bit accumulator and a 32-bit product register. Both registers are exposed as two 16-bit halves, and the accumulator halves can also be written one at a time.

A command is presented with `in_valid` and is taken on a rising edge where `in_ready` is also high. `in_ready` is high from the first edge after reset, except in a cycle where `acc_wr_en` requests a half write. A half write has priority, and any command offered in that cycle stays pending. When `in_valid` is low nothing is consumed.

The block has three ways of accumulating:
- **Narrow single mode:** the low 32 bits of the shifted 64-bit product accumulate into the accumulator, and the product register takes the low 32 bits of the unshifted product.
- **Wide single mode:** the accumulator and the product register together form one 64-bit accumulator, with the accumulator as the upper word.
- **Dual mode:** the high-pair product accumulates into the accumulator and the low-pair product accumulates into the product register, both in the same cycle.

Top module: `mac_dual_unit`

## Requirements
- R1: After reset the accumulator, the product register and the overflow flag are zero, and `in_ready` is 1 from the first clock edge after reset is released.
- R2: With `dual_mode`=0, the product is the signed 32x32 product of `op_a` and `op_b`. In narrow mode (`wide_mode`=0), any accepted command other than hold loads the low 32 bits of the unshifted product into the product register.
- R3: With `dual_mode`=1, the signed product `op_a[31:16]*op_b[31:16]` is shifted and accumulated into the accumulator. In the same cycle the signed product `op_a[15:0]*op_b[15:0]` is shifted and accumulated into the product register. `wide_mode` is ignored in this mode.
- R4: `shift_left`=1 shifts the product left with zero fill. `shift_left`=0 shifts it right arithmetically. The shift is by `shift_amt` positions, and any value above 16 acts as 16.
- R5: The `acc_op` codes are 00 load (the target becomes the shifted product), 01 add, 10 subtract (target minus shifted product) and 11 hold (no register changes).
- R6: In the 32-bit lanes, an add or subtract whose signed result overflows is clamped to 0x7FFFFFFF (positive overflow) or 0x80000000 (negative overflow) when `sat_en`=1. When `sat_en`=0 the result wraps.
- R7: With `wide_mode`=1 in single mode, {accumulator, product register} is a 64-bit accumulator. It takes the shifted 64-bit product, and with `sat_en`=1 it saturates to 0x7FFFFFFFFFFFFFFF or 0x8000000000000000.
- R8: `ovf_q` is set by an accepted add or subtract that overflows in any active lane, whether or not saturation is on. It then stays set until an accepted load clears it.
- R9: When `acc_wr_en`=1, `acc_wr_data` replaces the high half (`acc_wr_hi`=1) or the low half (`acc_wr_hi`=0) of the accumulator. The other half and the product register are unchanged, and `in_ready` is 0 in that cycle.
- R10: The registers change only on an edge where a command is accepted or a half write occurs. Results are visible from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Command can be taken this cycle |
| op_a | input | 32 | Operand A (two signed halves in dual mode) |
| op_b | input | 32 | Operand B (two signed halves in dual mode) |
| dual_mode | input | 1 | 1: two 16x16 lanes, 0: one 32x32 product |
| wide_mode | input | 1 | Single mode only: 1 selects 64-bit accumulation |
| shift_left | input | 1 | Shift direction, 1 left, 0 right arithmetic |
| shift_amt | input | 5 | Shift distance, values above 16 act as 16 |
| acc_op | input | 2 | 00 load, 01 add, 10 subtract, 11 hold |
| sat_en | input | 1 | Saturate on overflow |
| acc_wr_en | input | 1 | Write one accumulator half |
| acc_wr_hi | input | 1 | Half select, 1 high, 0 low |
| acc_wr_data | input | 16 | Half-write data |
| acc_q | output | 32 | Accumulator (high half in bits 31:16) |
| prod_q | output | 32 | Product register (high half in bits 31:16) |
| ovf_q | output | 1 | Sticky overflow flag |

## Verification
Every result comes from a single register stage. The accumulator, the product register and the flag therefore hold their new values from the rising edge that accepts the command or the half write, and not one cycle later. `in_ready` is combinational and falls within the same cycle that `acc_wr_en` rises. The bench drives every input on a falling edge and lets exactly one rising edge pass. It then compares all outputs at the next falling edge, against a behavioural model updated for that same accepted command. `in_ready` is sampled shortly after the half-write request is driven, before the edge that applies the write.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_HOLD = 2'b11
  } acc_op_e;

endpackage

// File: rtl/mac_pp_array.sv
// Four signed (H+1)x(H+1) partial products. In single mode the low halves are
// zero-extended and the four terms are recombined into one signed full product.
// In dual mode the low halves are sign-extended, and terms 3 and 0 are the two
// independent half-word products.
module mac_pp_array #(
  parameter int DW = 32,
  localparam int HW = DW / 2,
  localparam int FW = 2 * DW
) (
  input  logic          dual,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [FW-1:0] full,
  output logic [DW-1:0] pair_hi,
  output logic [DW-1:0] pair_lo
);
  localparam int PW = 2 * (HW + 1);

  logic signed [HW:0]   a_hi_x, a_lo_x, b_hi_x, b_lo_x;
  logic signed [PW-1:0] pp  [4];
  logic signed [FW-1:0] ext [4];
  logic signed [FW-1:0] sum;

  assign a_hi_x = {a[DW-1], a[DW-1:HW]};
  assign b_hi_x = {b[DW-1], b[DW-1:HW]};
  assign a_lo_x = {dual & a[HW-1], a[HW-1:0]};
  assign b_lo_x = {dual & b[HW-1], b[HW-1:0]};

  // index bit 1 picks the half of a, bit 0 the half of b
  for (genvar gi = 0; gi < 4; gi++) begin : g_pp
    localparam bit A_HI = (gi / 2) == 1;
    localparam bit B_HI = (gi % 2) == 1;
    logic signed [HW:0]   xa, xb;
    logic signed [PW-1:0] xa_w, xb_w;
    assign xa      = A_HI ? a_hi_x : a_lo_x;
    assign xb      = B_HI ? b_hi_x : b_lo_x;
    assign xa_w    = {{(PW-HW-1){xa[HW]}}, xa};
    assign xb_w    = {{(PW-HW-1){xb[HW]}}, xb};
    assign pp[gi]  = xa_w * xb_w;
    assign ext[gi] = {{(FW-PW){pp[gi][PW-1]}}, pp[gi]};
  end

  assign sum     = (ext[3] <<< DW) + ((ext[2] + ext[1]) <<< HW) + ext[0];
  assign full    = $unsigned(sum);
  assign pair_hi = pp[3][DW-1:0];
  assign pair_lo = pp[0][DW-1:0];

endmodule

// File: rtl/mac_shifter.sv
// Left shift with zero fill or arithmetic right shift, distance clamped to MAXSH.
module mac_shifter #(
  parameter int W     = 32,
  parameter int AW    = 5,
  parameter int MAXSH = 16
) (
  input  logic [W-1:0]  din,
  input  logic          left,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  localparam logic [AW-1:0] MAXV = AW'(MAXSH);

  logic [AW-1:0] amt_e;

  assign amt_e = (amt > MAXV) ? MAXV : amt;
  assign dout  = left ? (din << amt_e) : $unsigned($signed(din) >>> amt_e);

endmodule

// File: rtl/mac_acc_lane.sv
// One accumulate lane: load, add, subtract or hold, with overflow detection
// and optional clamping to the signed extremes of the lane width.
module mac_acc_lane
  import mac_pkg::*;
#(
  parameter int W = 32
) (
  input  acc_op_e      op,
  input  logic         sat_en,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] addend,
  output logic [W-1:0] nxt,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W:0] c_x, d_x, s_x;

  assign c_x = {cur[W-1], cur};
  assign d_x = {addend[W-1], addend};
  assign s_x = (op == OP_SUB) ? (c_x - d_x) : (c_x + d_x);

  always_comb begin
    ovf = 1'b0;
    nxt = cur;
    case (op)
      OP_LOAD: nxt = addend;
      OP_ADD, OP_SUB: begin
        ovf = s_x[W] ^ s_x[W-1];
        if (ovf && sat_en) nxt = s_x[W] ? MINV : MAXV;
        else               nxt = s_x[W-1:0];
      end
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/mac_dual_unit.sv
module mac_dual_unit
  import mac_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SHMAX = 16,
  localparam int HW   = DW / 2,
  localparam int SAW  = $clog2(SHMAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  op_a,
  input  logic [DW-1:0]  op_b,
  input  logic           dual_mode,
  input  logic           wide_mode,
  input  logic           shift_left,
  input  logic [SAW-1:0] shift_amt,
  input  logic [1:0]     acc_op,
  input  logic           sat_en,
  input  logic           acc_wr_en,
  input  logic           acc_wr_hi,
  input  logic [HW-1:0]  acc_wr_data,
  output logic [DW-1:0]  acc_q,
  output logic [DW-1:0]  prod_q,
  output logic           ovf_q
);
  localparam int FW = 2 * DW;

  acc_op_e       op_e;
  logic          fire, rdy_r;
  logic [DW-1:0] acc_r, prod_r, acc_nx, prod_nx;
  logic          ovf_r, ovf_nx, ovf_evt;

  logic [FW-1:0] prod_full, sh_full, lane_w_nx;
  logic [DW-1:0] pair_hi, pair_lo, sh_hi, sh_lo;
  logic [DW-1:0] lane_a_add, lane_a_nx, lane_b_nx;
  logic          lane_w_ovf, lane_a_ovf, lane_b_ovf;

  assign op_e     = acc_op_e'(acc_op);
  assign in_ready = rdy_r & ~acc_wr_en;
  assign fire     = in_valid & in_ready;

  // shared partial-product array
  mac_pp_array #(.DW(DW)) u_pp (
    .dual    (dual_mode),
    .a       (op_a),
    .b       (op_b),
    .full    (prod_full),
    .pair_hi (pair_hi),
    .pair_lo (pair_lo)
  );

  // product shifters: full width for single mode, one per lane for dual mode
  mac_shifter #(.W(FW), .AW(SAW), .MAXSH(SHMAX)) u_sh_full (
    .din (prod_full), .left (shift_left), .amt (shift_amt), .dout (sh_full)
  );
  mac_shifter #(.W(DW), .AW(SAW), .MAXSH(SHMAX)) u_sh_hi (
    .din (pair_hi), .left (shift_left), .amt (shift_amt), .dout (sh_hi)
  );
  mac_shifter #(.W(DW), .AW(SAW), .MAXSH(SHMAX)) u_sh_lo (
    .din (pair_lo), .left (shift_left), .amt (shift_amt), .dout (sh_lo)
  );

  // accumulate lanes
  assign lane_a_add = dual_mode ? sh_hi : sh_full[DW-1:0];

  mac_acc_lane #(.W(FW)) u_lane_w (
    .op (op_e), .sat_en (sat_en), .cur ({acc_r, prod_r}), .addend (sh_full),
    .nxt (lane_w_nx), .ovf (lane_w_ovf)
  );
  mac_acc_lane #(.W(DW)) u_lane_a (
    .op (op_e), .sat_en (sat_en), .cur (acc_r), .addend (lane_a_add),
    .nxt (lane_a_nx), .ovf (lane_a_ovf)
  );
  mac_acc_lane #(.W(DW)) u_lane_b (
    .op (op_e), .sat_en (sat_en), .cur (prod_r), .addend (sh_lo),
    .nxt (lane_b_nx), .ovf (lane_b_ovf)
  );

  // result steering per mode
  always_comb begin
    acc_nx  = acc_r;
    prod_nx = prod_r;
    ovf_evt = 1'b0;
    if (dual_mode) begin
      acc_nx  = lane_a_nx;
      prod_nx = lane_b_nx;
      ovf_evt = lane_a_ovf | lane_b_ovf;
    end else if (wide_mode) begin
      {acc_nx, prod_nx} = lane_w_nx;
      ovf_evt = lane_w_ovf;
    end else begin
      acc_nx  = lane_a_nx;
      ovf_evt = lane_a_ovf;
      if (op_e != OP_HOLD) prod_nx = prod_full[DW-1:0];
    end
    if (op_e == OP_LOAD)  ovf_nx = 1'b0;
    else if (ovf_evt)     ovf_nx = 1'b1;
    else                  ovf_nx = ovf_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_r  <= 1'b0;
      acc_r  <= '0;
      prod_r <= '0;
      ovf_r  <= 1'b0;
    end else begin
      rdy_r <= 1'b1;
      if (acc_wr_en) begin
        if (acc_wr_hi) acc_r[DW-1:HW] <= acc_wr_data;
        else           acc_r[HW-1:0]  <= acc_wr_data;
      end else if (fire) begin
        acc_r  <= acc_nx;
        prod_r <= prod_nx;
        ovf_r  <= ovf_nx;
      end
    end
  end

  assign acc_q  = acc_r;
  assign prod_q = prod_r;
  assign ovf_q  = ovf_r;

  // ---------------- assertions ----------------
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && acc_op == 2'b11) |=> ($stable(acc_q) && $stable(prod_q)));

  assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && acc_op == 2'b00) |=> !ovf_q);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(fire && acc_op == 2'b00)) |=> ovf_q);

  assert_half_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr_en && acc_wr_hi) |=>
      (acc_q[HW-1:0] == $past(acc_q[HW-1:0]) && acc_q[DW-1:HW] == $past(acc_wr_data)
       && $stable(prod_q)));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !acc_wr_en) |=> ($stable(acc_q) && $stable(prod_q) && $stable(ovf_q)));

endmodule

// File: tb/mac_dual_unit_tb.sv
`timescale 1ns/1ps
module mac_dual_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0, op_b = '0;
  logic        dual_mode = 1'b0, wide_mode = 1'b0, shift_left = 1'b0, sat_en = 1'b0;
  logic [4:0]  shift_amt = '0;
  logic [1:0]  acc_op = 2'b11;
  logic        acc_wr_en = 1'b0, acc_wr_hi = 1'b0;
  logic [15:0] acc_wr_data = '0;
  logic [31:0] acc_q, prod_q;
  logic        ovf_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_acc = '0, m_prod = '0;
  logic        m_ovf = 1'b0;

  always #2 clk = ~clk;

  mac_dual_unit dut_i (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .op_a (op_a), .op_b (op_b), .dual_mode (dual_mode), .wide_mode (wide_mode),
    .shift_left (shift_left), .shift_amt (shift_amt), .acc_op (acc_op), .sat_en (sat_en),
    .acc_wr_en (acc_wr_en), .acc_wr_hi (acc_wr_hi), .acc_wr_data (acc_wr_data),
    .acc_q (acc_q), .prod_q (prod_q), .ovf_q (ovf_q)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // ---------- behavioural model ----------
  task automatic lane32(input logic [31:0] cur, input logic [31:0] ad, input logic [1:0] op,
                        input logic sat, output logic [31:0] res, output logic ov);
    longint c, d, s;
    c = longint'($signed(cur));
    d = longint'($signed(ad));
    s = (op == 2'b10) ? c - d : c + d;
    ov = 1'b0;
    if (op == 2'b00) res = ad;
    else begin
      ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      if (ov && sat) res = (s < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      else           res = s[31:0];
    end
  endtask

  task automatic lane64(input logic [63:0] cur, input logic [63:0] ad, input logic [1:0] op,
                        input logic sat, output logic [63:0] res, output logic ov);
    logic signed [64:0] c, d, s;
    c = {cur[63], cur};
    d = {ad[63], ad};
    s = (op == 2'b10) ? c - d : c + d;
    ov = 1'b0;
    if (op == 2'b00) res = ad;
    else begin
      ov = s[64] ^ s[63];
      if (ov && sat) res = s[64] ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF;
      else           res = s[63:0];
    end
  endtask

  task automatic model_op(input logic [31:0] a, input logic [31:0] b, input logic dual,
                          input logic wide, input logic left, input logic [4:0] amt,
                          input logic [1:0] op, input logic sat);
    int e;
    logic [31:0] r1, r2;
    logic [63:0] r64;
    logic o1, o2;
    longint pa, pb, p, s;
    logic signed [31:0] ph, pl, sh1, sh2;
    e = (amt > 5'd16) ? 16 : int'(amt);
    if (op == 2'b11) return;
    o1 = 1'b0; o2 = 1'b0;
    if (dual) begin
      ph  = 32'($signed(a[31:16])) * 32'($signed(b[31:16]));
      pl  = 32'($signed(a[15:0])) * 32'($signed(b[15:0]));
      sh1 = left ? (ph <<< e) : (ph >>> e);
      sh2 = left ? (pl <<< e) : (pl >>> e);
      lane32(m_acc, sh1, op, sat, r1, o1);
      lane32(m_prod, sh2, op, sat, r2, o2);
      m_acc = r1; m_prod = r2;
    end else begin
      pa = longint'($signed(a));
      pb = longint'($signed(b));
      p  = pa * pb;
      s  = left ? (p <<< e) : (p >>> e);
      if (wide) begin
        lane64({m_acc, m_prod}, s, op, sat, r64, o1);
        {m_acc, m_prod} = r64;
      end else begin
        lane32(m_acc, s[31:0], op, sat, r1, o1);
        m_acc = r1; m_prod = p[31:0];
      end
    end
    if (op == 2'b00) m_ovf = 1'b0;
    else if (o1 || o2) m_ovf = 1'b1;
  endtask

  task automatic cmp_all(input string tag);
    chk({tag, " acc"}, 64'(acc_q), 64'(m_acc));
    chk({tag, " prod"}, 64'(prod_q), 64'(m_prod));
    chk({tag, " ovf"}, 64'(ovf_q), 64'(m_ovf));
  endtask

  task automatic apply(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic dual, input logic wide, input logic left,
                       input logic [4:0] amt, input logic [1:0] op, input logic sat);
    op_a = a; op_b = b; dual_mode = dual; wide_mode = wide; shift_left = left;
    shift_amt = amt; acc_op = op; sat_en = sat; in_valid = 1'b1;
    step();
    in_valid = 1'b0;
    model_op(a, b, dual, wide, left, amt, op, sat);
    cmp_all(tag);
  endtask

  task automatic wr_half(input string tag, input logic hi, input logic [15:0] d);
    acc_wr_en = 1'b1; acc_wr_hi = hi; acc_wr_data = d;
    #1;
    chk({tag, " R9 ready low"}, 64'(in_ready), 64'd0);
    step();
    acc_wr_en = 1'b0;
    if (hi) m_acc[31:16] = d; else m_acc[15:0] = d;
    cmp_all({tag, " R9"});
  endtask

  // ---------- scenarios ----------
  task automatic t_reset();
    chk("R1 acc", 64'(acc_q), 64'd0);
    chk("R1 prod", 64'(prod_q), 64'd0);
    chk("R1 ovf", 64'(ovf_q), 64'd0);
    chk("R1 ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_single();
    apply("R2 load", 32'd100000, 32'd300000, 0, 0, 0, 5'd0, 2'b00, 0);
    chk("R2 prod hand", 64'(prod_q), 64'h0000_0000_FC23_AC00);
    apply("R5 add", 32'h1234_5678, 32'h9ABC_DEF0, 0, 0, 0, 5'd0, 2'b01, 0);
    apply("R5 sub", 32'hFFFF_FFF9, 32'd13, 0, 0, 0, 5'd0, 2'b10, 0);
    apply("R2 neg x neg", 32'h8000_0000, 32'h8000_0000, 0, 0, 1, 5'd0, 2'b00, 0);
  endtask

  task automatic t_shift();
    apply("R4 right4", 32'hFFFF_FF00, 32'd1, 0, 0, 0, 5'd4, 2'b00, 0);
    chk("R4 right4 hand", 64'(acc_q), 64'h0000_0000_FFFF_FFF0);
    apply("R4 left16", 32'd3, 32'd1, 0, 0, 1, 5'd16, 2'b00, 0);
    chk("R4 left16 hand", 64'(acc_q), 64'h0000_0000_0003_0000);
    apply("R4 clamp31", 32'h8765_4321, 32'h0123_4567, 0, 0, 0, 5'd31, 2'b00, 0);
    apply("R4 clamp20 left", 32'd5, 32'd1, 0, 0, 1, 5'd20, 2'b00, 0);
    chk("R4 clamp20 hand", 64'(acc_q), 64'h0000_0000_0005_0000);
  endtask

  task automatic t_sat32();
    apply("R6 prep", 32'd0, 32'd0, 0, 0, 0, 5'd0, 2'b00, 0);
    wr_half("sat hi", 1, 16'h7FFF);
    wr_half("sat lo", 0, 16'hFFF0);
    apply("R6 sat pos", 32'd1, 32'h100, 0, 0, 0, 5'd0, 2'b01, 1);
    chk("R6 clamp max", 64'(acc_q), 64'h0000_0000_7FFF_FFFF);
    chk("R8 set", 64'(ovf_q), 64'd1);
    apply("R8 sticky", 32'd1, 32'd1, 0, 0, 0, 5'd0, 2'b01, 0);
    chk("R8 stays", 64'(ovf_q), 64'd1);
    apply("R8 load clears", 32'd2, 32'd3, 0, 0, 0, 5'd0, 2'b00, 0);
    chk("R8 cleared", 64'(ovf_q), 64'd0);
    wr_half("wrap hi", 1, 16'h7FFF);
    wr_half("wrap lo", 0, 16'hFFF0);
    apply("R6 wrap", 32'd1, 32'h100, 0, 0, 0, 5'd0, 2'b01, 0);
    chk("R6 wrapped", 64'(acc_q), 64'h0000_0000_8000_00F0);
    wr_half("neg hi", 1, 16'h8000);
    wr_half("neg lo", 0, 16'h0010);
    apply("R6 sat neg", 32'd1, 32'h100, 0, 0, 0, 5'd0, 2'b10, 1);
    chk("R6 clamp min", 64'(acc_q), 64'h0000_0000_8000_0000);
  endtask

  task automatic t_dual();
    apply("R3 load", {16'd3, 16'hFFFB}, {16'hFFF9, 16'd11}, 1, 1, 0, 5'd0, 2'b00, 0);
    chk("R3 hi pair", 64'(acc_q), 64'h0000_0000_FFFF_FFEB);
    chk("R3 lo pair", 64'(prod_q), 64'h0000_0000_FFFF_FFC9);
    apply("R3 add shifted", {16'h8000, 16'h1234}, {16'h7FFF, 16'hABCD}, 1, 0, 1, 5'd3, 2'b01, 0);
    apply("R3 sub", {16'h0101, 16'h8000}, {16'hFF00, 16'h8000}, 1, 0, 0, 5'd2, 2'b10, 1);
    apply("R3 R6 sat", {16'h7FFF, 16'h7FFF}, {16'h7FFF, 16'h7FFF}, 1, 0, 1, 5'd16, 2'b01, 1);
  endtask

  task automatic t_wide();
    apply("R7 load", 32'hDEAD_BEEF, 32'h1357_9BDF, 0, 1, 0, 5'd0, 2'b00, 0);
    apply("R7 add", 32'h7FFF_0001, 32'h0F0F_0F0F, 0, 1, 1, 5'd8, 2'b01, 0);
    apply("R7 sub", 32'h0000_1234, 32'h8000_0000, 0, 1, 0, 5'd5, 2'b10, 0);
    apply("R7 prep", 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 5'd0, 2'b00, 0);
    wr_half("w hi", 1, 16'h7FFF);
    wr_half("w lo", 0, 16'hFFFF);
    apply("R7 sat", 32'd1, 32'd1, 0, 1, 0, 5'd0, 2'b01, 1);
    chk("R7 max hi", 64'(acc_q), 64'h0000_0000_7FFF_FFFF);
    chk("R7 max lo", 64'(prod_q), 64'h0000_0000_FFFF_FFFF);
    apply("R7 wrap", 32'd1, 32'd1, 0, 1, 0, 5'd0, 2'b01, 0);
    chk("R7 wrap hi", 64'(acc_q), 64'h0000_0000_8000_0000);
    chk("R7 wrap lo", 64'(prod_q), 64'd0);
  endtask

  task automatic t_hold_idle();
    apply("R5 hold", 32'h1111_2222, 32'h3333_4444, 0, 0, 0, 5'd0, 2'b11, 1);
    apply("R5 hold dual", 32'h1111_2222, 32'h3333_4444, 1, 0, 1, 5'd1, 2'b11, 0);
    op_a = 32'hFFFF_0000; op_b = 32'h1234_0000; acc_op = 2'b00; in_valid = 1'b0;
    step(); step();
    cmp_all("R10 idle");
    // command offered during half write is held off, then taken
    op_a = 32'd9; op_b = 32'd9; dual_mode = 0; wide_mode = 0; shift_left = 0;
    shift_amt = 0; acc_op = 2'b00; sat_en = 0; in_valid = 1'b1;
    wr_half("R9 blocked", 1, 16'hA5A5);
    step();
    in_valid = 1'b0;
    model_op(32'd9, 32'd9, 0, 0, 0, 5'd0, 2'b00, 0);
    cmp_all("R10 after write");
    chk("R10 load value", 64'(acc_q), 64'd81);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_shift();
    t_sat32();
    t_dual();
    t_wide();
    t_hold_idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule